// File: doc/BRIEF.md
# Convolutional Byte Deinterleaver

This block undoes a byte-wise convolutional interleaver that spreads 204-byte error-protected frames over 12 branches. Each accepted input byte is steered to one branch by a rotating selector. Every branch is a fixed-length delay line, and the lengths shrink in steps of 17 (frame length over depth) from the first branch down to zero on the last. Added to the matching interleaver branch, each byte sees the same total delay, and the original byte order comes back out.

The selector is locked to the frame structure by a frame-start strobe. An upstream synchronisation detector raises that strobe together with the sync byte. All branch storage sits in one shared memory, and each branch has its own circular pointer. The output stays invalid until the longest branch has been filled. A bypass input sends the input bytes straight through with one cycle of latency, and the deinterleaving path keeps running underneath.

Top module: `conv_deinterleaver`

## Requirements
- R1: After reset, `out_valid` is low. Input bytes that arrive before the first accepted frame-start strobe are dropped and produce no output.
- R2: A byte presented with `in_valid` and `in_sof` both high always goes into branch 0, the longest line. The following accepted byte goes into branch 1.
- R3: The selector steps one branch for each accepted byte and wraps from branch 11 back to 0. Cycles with `in_valid` low neither move it nor produce output.
- R4: Branch j delays its bytes by (11 − j)·17 writes to that branch, and branch 11 has no delay. Counting accepted bytes from the sync byte (index 0), the valid output for index i is the input byte at index i − 204·(11 − i mod 12).
- R5: When the input is a stream interleaved with branch delays j·17, the output reproduces the original stream with a constant delay of 2244 accepted bytes.
- R6: After lock, `out_valid` stays low for accepted indices 0 to 2243. From index 2244 on, each accepted byte gives exactly one valid output byte in the following cycle.
- R7: A frame-start strobe on a byte that already falls on branch 0 changes nothing. A frame-start strobe on any other branch realigns the selector to branch 0 and restarts the fill, so `out_valid` stays low for the next 2244 accepted bytes.
- R8: With `bypass` high, `out_valid` and `out_data` repeat `in_valid` and `in_data` one cycle later. The deinterleaving path keeps tracking, so normal output resumes without a gap when `bypass` falls.
- R9: A frame-start strobe with `in_valid` low is ignored. It neither realigns nor restarts the fill.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bypass | input | 1 | Pass input bytes straight to the output |
| in_valid | input | 1 | Input byte is present this cycle |
| in_sof | input | 1 | Current byte is the frame sync byte |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte is valid |
| out_data | output | 8 | Deinterleaved (or bypassed) byte |

## Verification
The frame-start strobe and the selector's natural wrap to branch 0 can fall on the same byte. In that case the strobe must not restart the fill, although the same strobe on any other branch must. The bench sends sync strobes every 204 bytes, which always coincide with a wrap, and checks that the output stays valid and correct across each of them. It then places one strobe on branch 5 and checks that `out_valid` drops and comes back exactly 2244 accepted bytes later. A strobe without `in_valid`, also on a non-zero branch, checks that the realign logic needs the two signals together.

// File: rtl/dil_pkg.sv
package dil_pkg;

  // delay (in branch writes) of branch j
  function automatic int branch_delay(input int j, input int depth, input int unit);
    return (depth - 1 - j) * unit;
  endfunction

  // first memory cell of branch j: sum of the delays of branches 0..j-1
  function automatic int branch_base(input int j, input int depth, input int unit);
    return unit * (j * (depth - 1) - (j * (j - 1)) / 2);
  endfunction

  // total cells over all branches
  function automatic int total_cells(input int depth, input int unit);
    return unit * depth * (depth - 1) / 2;
  endfunction

  // accepted bytes until the longest branch has been filled
  function automatic int fill_length(input int depth, input int unit);
    return unit * depth * (depth - 1);
  endfunction

endpackage

// File: rtl/dil_commutator.sv
module dil_commutator #(
  parameter int DEPTH = 12,
  localparam int BW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sof,
  output logic          accept,
  output logic          realign,
  output logic [BW-1:0] branch
);
  localparam logic [BW-1:0] LAST  = BW'(DEPTH - 1);
  localparam logic [BW-1:0] AFTER0 = (DEPTH > 1) ? BW'(1) : '0;

  logic          locked_q;
  logic [BW-1:0] cur_q;
  logic          sync_byte;

  assign sync_byte = in_valid && in_sof;
  assign accept    = in_valid && (locked_q || in_sof);
  assign realign   = sync_byte && (!locked_q || (cur_q != '0));
  assign branch    = sync_byte ? '0 : cur_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      cur_q    <= '0;
    end else if (accept) begin
      locked_q <= 1'b1;
      cur_q    <= (branch == LAST) ? '0 : branch + BW'(1);
    end
  end

  // R2: the sync byte anchors the selector at branch 0
  p_anchor_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sync_byte |=> (cur_q == AFTER0));

  // R3: one step per accepted non-sync byte, wrapping at the end
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !in_sof) |=>
      (cur_q == (($past(cur_q) == LAST) ? '0 : BW'($past(cur_q) + BW'(1)))));

  // R3: no movement without an accepted byte
  p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(cur_q));

endmodule

// File: rtl/dil_fill_tracker.sv
module dil_fill_tracker #(
  parameter int FILL = 2244,
  localparam int CW = $clog2(FILL + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic realign,
  output logic byte_ok
);
  logic [CW-1:0] cnt_q;

  // accepted byte index since the last (re)alignment, saturating at FILL
  assign byte_ok = accept && !realign && (cnt_q >= CW'(FILL));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (accept) begin
      if (realign)                 cnt_q <= CW'(1);
      else if (cnt_q < CW'(FILL))  cnt_q <= cnt_q + CW'(1);
    end
  end

  // R7: a realignment restarts the fill count
  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && realign) |=> (cnt_q == CW'(1)));

  // R6: the count never passes the fill length
  p_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CW'(FILL)) && !realign |=> (cnt_q == CW'(FILL)));

endmodule

// File: rtl/dil_delay_store.sv
module dil_delay_store #(
  parameter int DEPTH = 12,
  parameter int UNIT  = 17,
  parameter int W     = 8,
  localparam int BW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CELLS = (dil_pkg::total_cells(DEPTH, UNIT) > 1) ? dil_pkg::total_cells(DEPTH, UNIT) : 2,
  localparam int AW    = $clog2(CELLS),
  localparam int MAXD  = ((DEPTH - 1) * UNIT > 1) ? (DEPTH - 1) * UNIT : 2,
  localparam int PW    = $clog2(MAXD)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [BW-1:0] branch,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout
);
  logic [W-1:0]  mem [CELLS];
  logic [AW-1:0] base_w   [DEPTH];
  logic [PW-1:0] ptr_q    [DEPTH];
  logic          direct_w [DEPTH];
  logic [AW-1:0] addr;
  logic          direct;

  for (genvar j = 0; j < DEPTH; j++) begin : g_branch
    localparam int DLY  = dil_pkg::branch_delay(j, DEPTH, UNIT);
    localparam int BASE = dil_pkg::branch_base(j, DEPTH, UNIT);
    assign base_w[j] = AW'(BASE);
    if (DLY == 0) begin : g_direct
      assign direct_w[j] = 1'b1;
      assign ptr_q[j]    = '0;
    end else begin : g_line
      logic hit;
      assign direct_w[j] = 1'b0;
      assign hit = wr && (branch == BW'(j));
      always_ff @(posedge clk) begin
        if (!rst_n)   ptr_q[j] <= '0;
        else if (hit) ptr_q[j] <= (ptr_q[j] == PW'(DLY - 1)) ? '0 : ptr_q[j] + PW'(1);
      end
      // R4: each circular pointer wraps after exactly its branch delay
      p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && (ptr_q[j] == PW'(DLY - 1))) |=> (ptr_q[j] == '0));
    end
  end

  assign direct = direct_w[branch];
  assign addr   = base_w[branch] + AW'(ptr_q[branch]);

  // read the oldest byte of the branch and overwrite it in the same edge
  always_ff @(posedge clk) begin
    if (wr) begin
      if (direct) begin
        dout <= din;
      end else begin
        dout      <= mem[addr];
        mem[addr] <= din;
      end
    end
  end

endmodule

// File: rtl/conv_deinterleaver.sv
module conv_deinterleaver #(
  parameter int DEPTH = 12,
  parameter int FRAME = 204,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bypass,
  input  logic         in_valid,
  input  logic         in_sof,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  localparam int UNIT = FRAME / DEPTH;
  localparam int FILL = dil_pkg::fill_length(DEPTH, UNIT);
  localparam int BW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic          accept;
  logic          realign;
  logic [BW-1:0] branch;
  logic          byte_ok;
  logic [W-1:0]  store_dout;
  logic          bypass_q;
  logic [W-1:0]  byp_data_q;

  dil_commutator #(.DEPTH(DEPTH)) u_comm (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .accept(accept), .realign(realign), .branch(branch)
  );

  dil_fill_tracker #(.FILL(FILL)) u_fill (
    .clk(clk), .rst_n(rst_n), .accept(accept), .realign(realign),
    .byte_ok(byte_ok)
  );

  dil_delay_store #(.DEPTH(DEPTH), .UNIT(UNIT), .W(W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr(accept), .branch(branch),
    .din(in_data), .dout(store_dout)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      bypass_q  <= 1'b0;
    end else begin
      out_valid <= bypass ? in_valid : byte_ok;
      bypass_q  <= bypass;
    end
  end

  always_ff @(posedge clk) byp_data_q <= in_data;

  assign out_data = bypass_q ? byp_data_q : store_dout;

  // R6: no output without an input byte in the cycle before
  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R8: bypass repeats the input one cycle later
  p_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && in_valid) |=> (out_valid && (out_data == $past(in_data))));

  // R1: nothing comes out before the first sync byte locks the selector
  p_nolock_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && !accept) |=> !out_valid);

endmodule

// File: tb/sim_conv_deinterleaver.sv
module sim_conv_deinterleaver;
  localparam int FILL = 2244;
  localparam int FR   = 204;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bypass = 1'b0, in_valid = 1'b0, in_sof = 1'b0;
  logic [7:0] in_data = '0;
  logic out_valid;
  logic [7:0] out_data;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  conv_deinterleaver u0 (.clk(clk), .rst_n(rst_n), .bypass(bypass), .in_valid(in_valid),
    .in_sof(in_sof), .in_data(in_data), .out_valid(out_valid), .out_data(out_data));

  always #5 clk = ~clk;

  // bench model state
  logic [7:0] hist [0:8191];
  int  idx = 0;
  bit  locked_m = 1'b0;
  int  seg_bad = 0, seg_n = 0, e2e_bad = 0, e2e_n = 0;
  int  first_idx = -1;
  int  bad_act = 0, bad_exp = 0;
  bit  e2e_on = 1'b0;
  int  g = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] sval(input int n);
    return (n % FR == 0) ? 8'h47 : 8'(n * 7 + 3);
  endfunction

  // interleaved stream: branch j = i mod 12 delayed by j*17 branch writes
  function automatic logic [7:0] xval(input int i);
    int n;
    n = i - FR * (i % 12);
    return (n < 0) ? 8'h00 : sval(n);
  endfunction

  task automatic drive(input bit v, input bit sof, input logic [7:0] d, input bit byp);
    bit acc, cv, ev;
    int ci;
    logic [7:0] cd, ed;
    cv = 1'b0; cd = '0; ci = -1;
    @(negedge clk);
    in_valid = v; in_sof = sof; in_data = d; bypass = byp;
    if (v && sof && (!locked_m || (idx % 12 != 0))) begin idx = 0; locked_m = 1'b1; end
    acc = v && locked_m;
    if (acc) begin
      hist[idx] = d;
      ci = idx;
      cv = (idx >= FILL);
      if (cv) cd = hist[idx - FR * (11 - idx % 12)];
      idx++;
    end
    ev = byp ? v : cv;
    ed = byp ? d : cd;
    @(posedge clk); #2;
    seg_n++;
    if (out_valid !== ev || (ev && out_data !== ed)) begin
      if (seg_bad == 0) begin
        bad_act = ev ? int'(out_data) : int'(out_valid);
        bad_exp = ev ? int'(ed) : int'(ev);
      end
      seg_bad++;
    end
    if (!byp && out_valid && first_idx < 0) first_idx = ci;
    if (e2e_on && !byp && cv) begin
      e2e_n++;
      if (out_data !== sval(ci - FILL)) e2e_bad++;
    end
    in_valid = 1'b0; in_sof = 1'b0;
  endtask

  task automatic seg_start();
    seg_bad = 0; seg_n = 0;
  endtask

  task automatic seg_check(input string req);
    check(seg_bad == 0, req, bad_act, bad_exp);
  endtask

  // send interleaved stream bytes; sync strobe on every frame start
  task automatic stream(input int count, input bit byp);
    for (int k = 0; k < count; k++) begin
      if (g % 37 == 36) drive(1'b0, 1'b0, 8'hEE, byp);
      drive(1'b1, (g % FR == 0), xval(g), byp);
      g++;
    end
  endtask

  task automatic t_reset();
    #1;
    check(out_valid === 1'b0, "R1 reset out_valid", int'(out_valid), 0);
  endtask

  task automatic t_prelock();
    seg_start();
    for (int k = 0; k < 24; k++) drive(1'b1, 1'b0, 8'(k + 100), 1'b0);
    seg_check("R1 bytes before lock");
  endtask

  task automatic t_fill_and_stream();
    seg_start(); first_idx = -1; e2e_on = 1'b1;
    stream(2700, 1'b0);
    check(first_idx == FILL, "R6 first valid index", first_idx, FILL);
    seg_check("R2 R3 R4 branch delays with gaps");
    check(e2e_bad == 0 && e2e_n > 400, "R5 end-to-end recovery", e2e_bad, 0);
    check(first_idx == FILL, "R7 frame syncs on branch 0 keep lock", first_idx, FILL);
  endtask

  task automatic t_sof_without_valid();
    int nv;
    while (g % 12 != 5) stream(1, 1'b0);
    seg_start();
    drive(1'b0, 1'b1, 8'h55, 1'b0);
    nv = 0;
    for (int k = 0; k < 30; k++) begin
      stream(1, 1'b0);
      if (out_valid) nv++;
    end
    check(nv == 30, "R9 strobe without valid ignored", nv, 30);
    seg_check("R9 data after lone strobe");
  endtask

  task automatic t_bypass();
    seg_start();
    stream(16, 1'b1);
    seg_check("R8 bypass passthrough");
    seg_start();
    stream(100, 1'b0);
    seg_check("R8 deinterleave resumes after bypass");
    check(e2e_bad == 0, "R8 R5 stream continuous after bypass", e2e_bad, 0);
  endtask

  task automatic t_realign();
    while (g % 12 != 5) stream(1, 1'b0);
    e2e_on = 1'b0; first_idx = -1;
    seg_start();
    drive(1'b1, 1'b1, 8'h47, 1'b0);
    check(out_valid === 1'b0, "R7 realign drops valid", int'(out_valid), 0);
    for (int k = 0; k < 2300; k++) begin
      if (k % 53 == 52) drive(1'b0, 1'b0, 8'h00, 1'b0);
      drive(1'b1, 1'b0, 8'(k * 13 + 1), 1'b0);
    end
    check(first_idx == FILL, "R7 refill after realign", first_idx, FILL);
    seg_check("R7 R4 data after realign");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_prelock();
    t_fill_and_stream();
    t_sof_without_valid();
    t_bypass();
    t_realign();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule